// File: doc/BRIEF.md
# Percentage Duty Cycle Timer

This block drives one output level through a repeating cycle whose total length is a preset number of timebase ticks. Each cycle opens with an on phase, whose length is the chosen percentage of the cycle, and fills the rest with an off phase. The on length is worked out from the cycle preset and the percentage when a cycle starts. A new cycle starts at the first power-up, at every wrap, and at every restart. The cycle position moves only on clock edges where the tick input is high, so the timebase can be set from outside.

The power input works as the block's run permission. A mode bit chooses what happens after a power loss. With memory enabled, the position is frozen while power is low, and timing goes on from that point when power returns. With memory disabled, power returning starts a fresh cycle at the beginning of the on phase. The output is low whenever power is low. The block keeps its memory only while the clock and reset remain valid, so it holds no state across a real loss of supply.

The controller has four states. IDLE means unpowered with no saved position. ON and OFF are the two phases of a running cycle. HOLD means unpowered with the position saved. The transitions are: IDLE to ON or OFF on power-up (start); ON to OFF when the position reaches the on length (phase end); ON or OFF to ON or OFF at a wrap (new cycle); ON or OFF to HOLD on power loss with memory enabled (pause); ON or OFF to IDLE on power loss without memory (drop); HOLD to ON or OFF on power return with memory enabled (resume); HOLD to IDLE when memory is switched off while unpowered (forget); HOLD to ON or OFF on power return without memory (restart).

Top module: `pct_duty_timer`

## Requirements
- R1: During and directly after reset the output is low and no cycle is running.
- R2: When power is sampled high with no saved position, a fresh cycle starts at position 0. The output goes high on the next clock if the on length is nonzero.
- R3: The cycle length t2 is the preset, with a preset of 0 treated as 1. The on length is t1 = floor(t2 * p / 100), where p is the clamped percentage.
- R4: The position advances by one only on clock edges where tick is high. The output is high while the position is below t1 and low for the remaining t2 - t1 positions. After position t2 - 1 the cycle wraps to 0.
- R5: With memory enabled, power loss freezes the position and the captured settings. When power returns, the cycle continues from the frozen position and phase.
- R6: With memory disabled, power returning starts a fresh cycle at position 0 in the on phase, with the settings recaptured.
- R7: The output is low on the clock after any edge at which power is sampled low, in both modes.
- R8: A percentage of 0 keeps the output low for the whole cycle. A percentage of 100 keeps it high for the whole cycle.
- R9: Percentage inputs above 100 behave exactly as 100.
- R10: Changes to the preset or the percentage during a cycle have no effect until the next cycle start (wrap, power-up or restart).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| power_i | input | 1 | Run permission level; low stands for power removed |
| tick_i | input | 1 | Timebase strobe; the position advances on edges where it is high |
| cycle_len_i | input | CNT_W | Cycle length preset t2 in ticks |
| percent_i | input | PCT_W | On share of the cycle in percent, 0 to 100, larger values clamped |
| memory_en_i | input | 1 | 1: pause and resume on power loss; 0: restart on power return |
| out_o | output | 1 | Timed output level |

## Verification
Every result comes from the state register alone. A power, tick or setting value sampled at one rising edge shows on the output right after that edge, so each result is due one cycle after its stimulus. The bench changes inputs only at falling edges. After each rising edge it advances its own model of the cycle one step, then compares the output with the model at the next falling edge, so the wait is exactly one cycle. Directed phases cover the timing of pause and resume, restart, the two constant settings, clamping and changes made mid-cycle. Random segments then mix all inputs, with cycle lengths short enough for many wraps.

// File: rtl/pct_pkg.sv
package pct_pkg;

    localparam int PCT_W    = 7;
    localparam int PCT_FULL = 100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2,
        ST_HOLD = 2'd3
    } tmr_state_e;

endpackage

// File: rtl/pct_scale.sv
module pct_scale
    import pct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] len_i,
    input  logic [PCT_W-1:0] pct_i,
    output logic [CNT_W-1:0] t2_o,
    output logic [CNT_W-1:0] t1_o
);

    localparam int PROD_W = CNT_W + PCT_W;
    localparam logic [PROD_W-1:0] DIVISOR = PROD_W'(PCT_FULL);
    localparam logic [PCT_W-1:0]  PCT_MAX = PCT_W'(PCT_FULL);

    logic [PCT_W-1:0]  pct_c;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        pct_c = (pct_i > PCT_MAX) ? PCT_MAX : pct_i;
        t2_o  = (len_i == '0) ? CNT_W'(1) : len_i;
        prod  = PROD_W'(t2_o) * PROD_W'(pct_c);
        quot  = prod / DIVISOR;
        t1_o  = quot[CNT_W-1:0];
    end

endmodule

// File: rtl/pct_cycle_fsm.sv
module pct_cycle_fsm
    import pct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             power_i,
    input  logic             tick_i,
    input  logic             memory_en_i,
    input  logic [CNT_W-1:0] t2_new_i,
    input  logic [CNT_W-1:0] t1_new_i,
    output logic             out_o,
    output tmr_state_e       state_o,
    output logic [CNT_W-1:0] pos_o,
    output logic [CNT_W-1:0] t1_o,
    output logic [CNT_W-1:0] t2_o
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] pos_q, pos_d;
    logic [CNT_W-1:0] t1_q, t1_d;
    logic [CNT_W-1:0] t2_q, t2_d;
    logic [CNT_W-1:0] pos_inc;
    logic             at_end;

    assign pos_inc = pos_q + CNT_W'(1);
    assign at_end  = (pos_inc == t2_q);

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        t1_d    = t1_q;
        t2_d    = t2_q;
        unique case (state_q)
            ST_IDLE: begin
                if (power_i) begin
                    pos_d   = '0;
                    t1_d    = t1_new_i;
                    t2_d    = t2_new_i;
                    state_d = (t1_new_i != '0) ? ST_ON : ST_OFF;
                end
            end
            ST_ON, ST_OFF: begin
                if (!power_i) begin
                    if (memory_en_i) begin
                        state_d = ST_HOLD;
                    end else begin
                        state_d = ST_IDLE;
                        pos_d   = '0;
                    end
                end else if (tick_i) begin
                    if (at_end) begin
                        pos_d   = '0;
                        t1_d    = t1_new_i;
                        t2_d    = t2_new_i;
                        state_d = (t1_new_i != '0) ? ST_ON : ST_OFF;
                    end else begin
                        pos_d   = pos_inc;
                        state_d = (pos_inc < t1_q) ? ST_ON : ST_OFF;
                    end
                end
            end
            ST_HOLD: begin
                if (!memory_en_i && !power_i) begin
                    state_d = ST_IDLE;
                    pos_d   = '0;
                end else if (power_i && memory_en_i) begin
                    state_d = (pos_q < t1_q) ? ST_ON : ST_OFF;
                end else if (power_i) begin
                    pos_d   = '0;
                    t1_d    = t1_new_i;
                    t2_d    = t2_new_i;
                    state_d = (t1_new_i != '0) ? ST_ON : ST_OFF;
                end
            end
            default: begin
                state_d = ST_IDLE;
                pos_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            t1_q    <= '0;
            t2_q    <= CNT_W'(1);
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            t1_q    <= t1_d;
            t2_q    <= t2_d;
        end
    end

    always_comb begin
        out_o   = (state_q == ST_ON);
        state_o = state_q;
        pos_o   = pos_q;
        t1_o    = t1_q;
        t2_o    = t2_q;
    end

endmodule

// File: rtl/pct_duty_timer.sv
module pct_duty_timer
    import pct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             power_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cycle_len_i,
    input  logic [PCT_W-1:0] percent_i,
    input  logic             memory_en_i,
    output logic             out_o
);

    logic [CNT_W-1:0] t2_new;
    logic [CNT_W-1:0] t1_new;
    tmr_state_e       cyc_state;
    logic [CNT_W-1:0] cyc_pos;
    logic [CNT_W-1:0] cyc_t1;
    logic [CNT_W-1:0] cyc_t2;

    pct_scale #(.CNT_W(CNT_W)) u_scale (
        .len_i (cycle_len_i),
        .pct_i (percent_i),
        .t2_o  (t2_new),
        .t1_o  (t1_new)
    );

    pct_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .power_i     (power_i),
        .tick_i      (tick_i),
        .memory_en_i (memory_en_i),
        .t2_new_i    (t2_new),
        .t1_new_i    (t1_new),
        .out_o       (out_o),
        .state_o     (cyc_state),
        .pos_o       (cyc_pos),
        .t1_o        (cyc_t1),
        .t2_o        (cyc_t2)
    );

endmodule

// File: rtl/pct_duty_timer_chk.sv
module pct_duty_timer_chk
    import pct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             power_i,
    input logic             tick_i,
    input logic             memory_en_i,
    input tmr_state_e       state_i,
    input logic [CNT_W-1:0] pos_i,
    input logic [CNT_W-1:0] t1_i,
    input logic [CNT_W-1:0] t2_i,
    input logic             out_i
);

    p_off_unpowered_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !power_i |=> !out_i);

    p_on_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t1_i <= t2_i);

    p_pos_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_i < t2_i);

    p_no_tick_still_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (power_i && !tick_i && (state_i == ST_ON || state_i == ST_OFF)) |=> $stable(pos_i));

    p_hold_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_HOLD && memory_en_i) |=> ($stable(pos_i) && $stable(t1_i)));

    p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(power_i) && !memory_en_i) |=> (pos_i == '0));

endmodule

bind pct_duty_timer pct_duty_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .power_i     (power_i),
    .tick_i      (tick_i),
    .memory_en_i (memory_en_i),
    .state_i     (cyc_state),
    .pos_i       (cyc_pos),
    .t1_i        (cyc_t1),
    .t2_i        (cyc_t2),
    .out_i       (out_o)
);

// File: tb/pct_duty_timer_tb_top.sv
`timescale 1ns/1ps
module pct_duty_timer_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             power = 1'b0;
    logic             tick = 1'b0;
    logic             mem_en = 1'b0;
    logic [CNT_W-1:0] len = '0;
    logic [6:0]       pct = '0;
    logic             out;

    always #2.5 clk = ~clk;

    pct_duty_timer #(.CNT_W(CNT_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .power_i     (power),
        .tick_i      (tick),
        .cycle_len_i (len),
        .percent_i   (pct),
        .memory_en_i (mem_en),
        .out_o       (out)
    );

    int errors = 0;
    int checks = 0;

    bit m_run;
    bit m_held;
    int m_pos;
    int m_t1;
    int m_t2;

    function automatic int calc_t2(int l);
        return (l == 0) ? 1 : l;
    endfunction

    function automatic int calc_t1(int l, int p);
        int pc;
        pc = (p > 100) ? 100 : p;
        return (calc_t2(l) * pc) / 100;
    endfunction

    function automatic bit exp_out();
        return m_run && (m_pos < m_t1);
    endfunction

    task automatic capture();
        m_t2  = calc_t2(int'(len));
        m_t1  = calc_t1(int'(len), int'(pct));
        m_pos = 0;
    endtask

    task automatic model_edge();
        if (!power) begin
            if (mem_en && (m_run || m_held)) begin
                m_held = 1'b1;
            end else begin
                m_held = 1'b0;
                m_pos  = 0;
            end
            m_run = 1'b0;
        end else if (m_run) begin
            if (tick) begin
                if (m_pos == m_t2 - 1) capture();
                else m_pos = m_pos + 1;
            end
        end else if (m_held && mem_en) begin
            m_run  = 1'b1;
            m_held = 1'b0;
        end else begin
            capture();
            m_run  = 1'b1;
            m_held = 1'b0;
        end
    endtask

    task automatic check(string tag, bit act, bit ex);
        checks++;
        if (act !== ex) begin
            errors++;
            $display("FAIL %s: out_o=%0b expected %0b at %0t", tag, act, ex, $time);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        check(tag, out, exp_out());
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_run = 1'b0; m_held = 1'b0; m_pos = 0; m_t1 = 0; m_t2 = 1;
        repeat (4) @(negedge clk);
        check("R1", out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", out, 1'b0);

        // R2 R4: 10-tick cycle at 50 percent, tick every clock
        len = 16'd10; pct = 7'd50; tick = 1'b1; power = 1'b1;
        run("R2", 1);
        run("R4", 30);

        // R4: sparse ticks
        for (int i = 0; i < 40; i++) begin
            tick = ($urandom_range(0, 2) == 0);
            cyc("R4");
        end
        tick = 1'b1;

        // R5: pause and resume with memory
        mem_en = 1'b1;
        run("R5", 7);
        power = 1'b0; run("R5", 5);
        power = 1'b1; run("R5", 12);

        // R6: restart without memory
        mem_en = 1'b0;
        run("R6", 3);
        power = 1'b0; run("R7", 3);
        power = 1'b1; run("R6", 12);

        // R8: constant levels
        pct = 7'd0;   run("R8", 40);
        pct = 7'd100; run("R8", 40);

        // R9: clamping above 100
        power = 1'b0; run("R7", 2);
        pct = 7'd127; power = 1'b1; run("R9", 30);

        // R10: mid-cycle changes
        len = 16'd20; pct = 7'd50;
        power = 1'b0; run("R7", 1);
        power = 1'b1; run("R10", 4);
        pct = 7'd10; len = 16'd8; run("R10", 40);

        // R3: preset 0 and rounding down
        len = 16'd0; pct = 7'd100; run("R3", 10);
        len = 16'd7; pct = 7'd33; run("R3", 30);

        // memory dropped while unpowered
        mem_en = 1'b1; run("R5", 4);
        power = 1'b0; run("R7", 2);
        mem_en = 1'b0; run("R6", 2);
        power = 1'b1; run("R6", 10);

        // random segments
        for (int s = 0; s < 300; s++) begin
            len    = CNT_W'($urandom_range(0, 20));
            pct    = 7'($urandom_range(0, 127));
            mem_en = $urandom_range(0, 1);
            power  = ($urandom_range(0, 3) != 0);
            for (int i = 0; i < int'($urandom_range(1, 60)); i++) begin
                tick = $urandom_range(0, 1);
                cyc("R4");
            end
        end

        summary();
    end

endmodule